// File: doc/BRIEF.md
# Accumulator Round-and-Store Path

This block turns a wide signed accumulator (40 bits by default: eight guard bits, a 1.15 high word and a 16-bit low word) into a 16-bit 1.15 word for storage. A store request can keep the high word as it is, which drops the low word. It can instead round the high word. Rounding is either biased, where any low word at half or above rounds up, or unbiased, where a low word that sits exactly on half rounds toward an even high word. When store saturation is enabled, the rounded value is then clamped into the signed 16-bit range.

A second lane writes back the accumulator that the operation did not target. This data is always rounded, using the same static round mode and the same saturation control. Its destination is either a working register, written directly, or a memory location that the register points to. In the memory form the pointer is then advanced by one word step (2 bytes).

Both lanes register their results, so every output appears one clock after its request.

Top module: `acc_store_path`

## Requirements
- R1: With `st_round_en` low and `sat_en` low, `st_data` equals accumulator bits 31..16, and the low word has no effect.
- R2: With rounding enabled and `rnd_mode`=0 (biased), the high word is incremented when bits 15..0 are 0x8000 or above, and left alone for 0x0000..0x7FFF.
- R3: With rounding enabled and `rnd_mode`=1 (unbiased), the result matches R2, except that a low word of exactly 0x8000 increments only when bit 16 is 1.
- R4: With `sat_en` high, a rounded value above +32767 gives 0x7FFF and one below -32768 gives 0x8000. This includes an overflow that rounding itself causes.
- R5: With `sat_en` low, the output is the low 16 bits of the rounded value, which wraps on overflow.
- R6: `st_wr` is high for exactly the cycle after a cycle with `st_valid` high, and `st_data` holds that request's result.
- R7: Write-back data is always rounded using `rnd_mode`, and is saturated under `sat_en` in the same way as a store.
- R8: In direct write-back (`wb_indirect`=0), `wb_mem` is 0 and `wb_ptr_upd` carries the written data, zero-extended, as the register's new value.
- R9: In indirect write-back (`wb_indirect`=1), `wb_mem` is 1, `wb_addr` equals the input pointer, and `wb_ptr_upd` equals the pointer plus 2, modulo the address width.
- R10: When `wb_en` is low, `wb_wr` stays low in the next cycle and `wb_data` keeps its value.
- R11: After reset, `st_wr` and `wb_wr` are low and `st_data` and `wb_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| st_valid | input | 1 | Store request |
| st_acc | input | ACC_W | Target accumulator |
| st_round_en | input | 1 | Round the store (otherwise drop the low word) |
| rnd_mode | input | 1 | 0 biased, 1 unbiased |
| sat_en | input | 1 | Saturate stored data to 16 bits |
| wb_en | input | 1 | Write-back request |
| wb_acc | input | ACC_W | Non-target accumulator |
| wb_indirect | input | 1 | 0 register direct, 1 through pointer with post-increment |
| wb_ptr | input | ADDR_W | Current pointer register value |
| st_wr | output | 1 | Store data strobe |
| st_data | output | DATA_W | Stored 1.15 word |
| wb_wr | output | 1 | Write-back strobe |
| wb_mem | output | 1 | Write-back goes to memory |
| wb_data | output | DATA_W | Write-back 1.15 word |
| wb_addr | output | ADDR_W | Memory address for write-back |
| wb_ptr_upd | output | ADDR_W | New pointer register value |

## Verification
The store lane is swept over high words next to zero and next to both 16-bit limits, with guard bytes that are sign-consistent and guard bytes that are not. Each of these is paired with the low words 0, 1, 0x7FFF, 0x8000, 0x8001 and 0xFFFF.

Because the high words include both odd and even values, the 0x8000 tie tells the unbiased mode apart from the biased one. The 0x7FFF and 0x8001 neighbours show that the two modes agree away from the tie. High word 0x7FFF with a large low word separates overflow caused by rounding from plain truncation, and the sign-inconsistent guards separate clamping from wrapping.

The write-back lane sees the same values under both addressing forms, with a pointer at the top of the address range to check the increment wrap. Some cycles leave it idle to show that its strobe and data are held.

// File: rtl/acc_store_pkg.sv
package acc_store_pkg;
   typedef enum logic {
      RND_BIASED   = 1'b0,
      RND_UNBIASED = 1'b1
   } rnd_mode_e;
endpackage

// File: rtl/acc_rounder.sv
module acc_rounder
   import acc_store_pkg::*;
#(
   parameter int ACC_W = 40,
   parameter int LO_W  = 16,
   localparam int HI_W = ACC_W - LO_W
) (
   input  logic [ACC_W-1:0] acc,
   input  logic             round_en,
   input  rnd_mode_e        mode,
   output logic [HI_W:0]    rounded
);
   localparam logic [LO_W-1:0] HALF = LO_W'(1) << (LO_W - 1);

   if (LO_W < 2) begin : g_bad_lo
      $error("acc_rounder: LO_W must be at least 2");
   end

   logic [LO_W-1:0] lo;
   logic            above, tie, hi_lsb, bump;

   always_comb begin
      lo     = acc[LO_W-1:0];
      above  = lo > HALF;
      tie    = lo == HALF;
      hi_lsb = acc[LO_W];
      bump   = round_en & (above | (tie & ((mode == RND_BIASED) | hi_lsb)));
      rounded = {acc[ACC_W-1], acc[ACC_W-1:LO_W]} + (HI_W+1)'(bump);
   end
endmodule

// File: rtl/acc_saturator.sv
module acc_saturator #(
   parameter int IN_W  = 25,
   parameter int OUT_W = 16
) (
   input  logic [IN_W-1:0]  val,
   input  logic             sat_en,
   output logic [OUT_W-1:0] res
);
   if (IN_W < OUT_W) begin : g_bad_w
      $error("acc_saturator: IN_W must not be below OUT_W");
   end

   localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};
   localparam logic [OUT_W-1:0] NEG_MAX = {1'b1, {(OUT_W-1){1'b0}}};

   if (IN_W > OUT_W) begin : g_clamp
      logic [IN_W-OUT_W:0] upper;
      logic                pos_ovf, neg_ovf;
      always_comb begin
         upper   = val[IN_W-1:OUT_W-1];
         pos_ovf = ~val[IN_W-1] & (|upper);
         neg_ovf = val[IN_W-1] & ~(&upper);
         if (sat_en && pos_ovf)      res = POS_MAX;
         else if (sat_en && neg_ovf) res = NEG_MAX;
         else                        res = val[OUT_W-1:0];
      end
   end else begin : g_pass
      logic unused_sat;
      assign unused_sat = sat_en;
      assign res = val;
   end
endmodule

// File: rtl/wb_addr_gen.sv
module wb_addr_gen #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int STEP   = 2
) (
   input  logic              indirect,
   input  logic [ADDR_W-1:0] ptr,
   input  logic [DATA_W-1:0] data,
   output logic              to_mem,
   output logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] ptr_next
);
   if (ADDR_W < DATA_W) begin : g_bad_a
      $error("wb_addr_gen: ADDR_W must hold a data word");
   end

   always_comb begin
      to_mem = indirect;
      if (indirect) begin
         addr     = ptr;
         ptr_next = ptr + ADDR_W'(STEP);
      end else begin
         addr     = '0;
         ptr_next = ADDR_W'(data);
      end
   end
endmodule

// File: rtl/acc_store_path.sv
module acc_store_path
   import acc_store_pkg::*;
#(
   parameter int ACC_W  = 40,
   parameter int DATA_W = 16,
   parameter int ADDR_W = 16,
   parameter int STEP   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              st_valid,
   input  logic [ACC_W-1:0]  st_acc,
   input  logic              st_round_en,
   input  logic              rnd_mode,
   input  logic              sat_en,
   input  logic              wb_en,
   input  logic [ACC_W-1:0]  wb_acc,
   input  logic              wb_indirect,
   input  logic [ADDR_W-1:0] wb_ptr,
   output logic              st_wr,
   output logic [DATA_W-1:0] st_data,
   output logic              wb_wr,
   output logic              wb_mem,
   output logic [DATA_W-1:0] wb_data,
   output logic [ADDR_W-1:0] wb_addr,
   output logic [ADDR_W-1:0] wb_ptr_upd
);
   localparam int LO_W = DATA_W;
   localparam int HI_W = ACC_W - LO_W;

   if (HI_W < DATA_W) begin : g_bad_acc
      $error("acc_store_path: ACC_W must hold guard plus data word plus low word");
   end

   rnd_mode_e mode;
   assign mode = rnd_mode_e'(rnd_mode);

   logic [HI_W:0]     st_rnd, wb_rnd;
   logic [DATA_W-1:0] st_sat, wb_sat;
   logic              ag_mem;
   logic [ADDR_W-1:0] ag_addr, ag_next;

   acc_rounder #(.ACC_W(ACC_W), .LO_W(LO_W)) i_rnd_st (
      .acc(st_acc), .round_en(st_round_en), .mode(mode), .rounded(st_rnd));
   acc_rounder #(.ACC_W(ACC_W), .LO_W(LO_W)) i_rnd_wb (
      .acc(wb_acc), .round_en(1'b1), .mode(mode), .rounded(wb_rnd));

   acc_saturator #(.IN_W(HI_W+1), .OUT_W(DATA_W)) i_sat_st (
      .val(st_rnd), .sat_en(sat_en), .res(st_sat));
   acc_saturator #(.IN_W(HI_W+1), .OUT_W(DATA_W)) i_sat_wb (
      .val(wb_rnd), .sat_en(sat_en), .res(wb_sat));

   wb_addr_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STEP(STEP)) i_agen (
      .indirect(wb_indirect), .ptr(wb_ptr), .data(wb_sat),
      .to_mem(ag_mem), .addr(ag_addr), .ptr_next(ag_next));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_wr      <= 1'b0;
         st_data    <= '0;
         wb_wr      <= 1'b0;
         wb_mem     <= 1'b0;
         wb_data    <= '0;
         wb_addr    <= '0;
         wb_ptr_upd <= '0;
      end else begin
         st_wr <= st_valid;
         wb_wr <= wb_en;
         if (st_valid) st_data <= st_sat;
         if (wb_en) begin
            wb_mem     <= ag_mem;
            wb_data    <= wb_sat;
            wb_addr    <= ag_addr;
            wb_ptr_upd <= ag_next;
         end
      end
   end

   // Store lane checks
   p_trunc_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && !st_round_en && !sat_en) |=> st_data == $past(st_acc[2*DATA_W-1:DATA_W]));
   p_tie_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && st_round_en && rnd_mode && !sat_en
       && st_acc[DATA_W-1:0] == {1'b1, {(DATA_W-1){1'b0}}} && !st_acc[DATA_W])
      |=> st_data == $past(st_acc[2*DATA_W-1:DATA_W]));
   p_sat_pos_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && sat_en && !st_acc[ACC_W-1] && |st_acc[ACC_W-2:2*DATA_W-1])
      |=> st_data == {1'b0, {(DATA_W-1){1'b1}}});
   p_sat_neg_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && sat_en && st_acc[ACC_W-1] && !(&st_acc[ACC_W-2:2*DATA_W]))
      |=> st_data == {1'b1, {(DATA_W-1){1'b0}}});
   p_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid |=> st_wr);
   p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !st_valid |=> !st_wr);

   // Write-back lane checks
   p_direct_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_wr && !wb_mem) |-> wb_ptr_upd == ADDR_W'(wb_data));
   p_ptr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_wr && wb_mem) |-> wb_ptr_upd == wb_addr + ADDR_W'(STEP));
   p_no_wb_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !wb_en |=> (!wb_wr && $stable(wb_data)));
endmodule

// File: tb/test_acc_store_path.sv
module test_acc_store_path;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        st_valid = 0, st_round_en = 0, rnd_mode = 0, sat_en = 0;
   logic        wb_en = 0, wb_indirect = 0;
   logic [39:0] st_acc = '0, wb_acc = '0;
   logic [15:0] wb_ptr = '0;
   logic        st_wr, wb_wr, wb_mem;
   logic [15:0] st_data, wb_data, wb_addr, wb_ptr_upd;

   int checks = 0, errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   acc_store_path i_acc_store_path (
      .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_acc(st_acc),
      .st_round_en(st_round_en), .rnd_mode(rnd_mode), .sat_en(sat_en),
      .wb_en(wb_en), .wb_acc(wb_acc), .wb_indirect(wb_indirect), .wb_ptr(wb_ptr),
      .st_wr(st_wr), .st_data(st_data), .wb_wr(wb_wr), .wb_mem(wb_mem),
      .wb_data(wb_data), .wb_addr(wb_addr), .wb_ptr_upd(wb_ptr_upd));

   task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic longint rnd_val(input logic [39:0] a, input bit re, input bit md);
      logic signed [23:0] h;
      longint r;
      h = a[39:16];
      r = h;
      if (re) begin
         if (a[15:0] > 16'h8000) r++;
         else if (a[15:0] == 16'h8000 && (!md || a[16])) r++;
      end
      return r;
   endfunction

   function automatic logic [15:0] model(input logic [39:0] a, input bit re, input bit md, input bit se);
      longint r;
      r = rnd_val(a, re, md);
      if (se && r > 32767)  return 16'h7FFF;
      if (se && r < -32768) return 16'h8000;
      return r[15:0];
   endfunction

   function automatic string tag_of(input logic [39:0] a, input bit re, input bit md, input bit se);
      longint r;
      r = rnd_val(a, re, md);
      if (r > 32767 || r < -32768) return se ? "R4" : "R5";
      if (!re) return "R1";
      return md ? "R3" : "R2";
   endfunction

   task automatic run(input logic [39:0] a, input bit re, input bit md, input bit se,
                      input bit we, input bit wi, input logic [15:0] p);
      logic [15:0] prev_wb, exp_st, exp_wb;
      @(negedge clk);
      prev_wb     = wb_data;
      st_acc      = a;
      st_round_en = re;
      rnd_mode    = md;
      sat_en      = se;
      st_valid    = 1'b1;
      wb_acc      = ~a;
      wb_en       = we;
      wb_indirect = wi;
      wb_ptr      = p;
      @(negedge clk);
      st_valid = 1'b0;
      wb_en    = 1'b0;
      exp_st = model(a, re, md, se);
      exp_wb = model(~a, 1'b1, md, se);
      chk(st_wr == 1'b1, "R6 strobe", 16'(st_wr), 16'h1);
      chk(st_data == exp_st, tag_of(a, re, md, se), st_data, exp_st);
      if (we) begin
         chk(wb_wr == 1'b1 && wb_data == exp_wb, "R7", wb_data, exp_wb);
         if (wi) begin
            chk(wb_mem == 1'b1 && wb_addr == p, "R9 addr", wb_addr, p);
            chk(wb_ptr_upd == p + 16'd2, "R9 step", wb_ptr_upd, p + 16'd2);
         end else begin
            chk(wb_mem == 1'b0 && wb_ptr_upd == exp_wb, "R8", wb_ptr_upd, exp_wb);
         end
      end else begin
         chk(wb_wr == 1'b0 && wb_data == prev_wb, "R10", wb_data, prev_wb);
      end
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [15:0] his [8] = '{16'h0000, 16'h0001, 16'h1234, 16'h7FFE,
                               16'h7FFF, 16'hFFFF, 16'h8000, 16'h8001};
      logic [7:0]  gds [4] = '{8'h00, 8'hFF, 8'h01, 8'hFE};
      logic [15:0] los [6] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'h8001, 16'hFFFF};
      int n = 0;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(st_wr == 0 && wb_wr == 0, "R11 strobes", {st_wr, wb_wr}, 16'h0);
      chk(st_data == 0 && wb_data == 0, "R11 data", st_data ^ wb_data, 16'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(st_wr == 0, "R6 idle", 16'(st_wr), 16'h0);
      for (int h = 0; h < 8; h++)
         for (int g = 0; g < 4; g++)
            for (int l = 0; l < 6; l++)
               for (int m = 0; m < 3; m++)
                  for (int s = 0; s < 2; s++) begin
                     n++;
                     run({gds[g], his[h], los[l]}, m != 0, m == 2, s == 1,
                         (n % 5) != 0, n[1], (n % 7 == 0) ? 16'hFFFE : 16'(n * 6));
                  end
      @(negedge clk);
      chk(st_wr == 0 && wb_wr == 0, "R6 idle end", {st_wr, wb_wr}, 16'h0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule